// File: doc/BRIEF.md
# Edge Phase Comparator for Motor Speed Lock

This block is the phase detector of a phase-locked speed loop for a three-phase brushless motor. It compares two edges. The reference edge is the falling edge of an external reference clock, which must already be synchronized to the system clock. The feedback edge is the rising edge of the motor's speed signal, which is the low-to-high transition of the first Hall phase. The loop settles when both signals run at the same frequency, so there is one feedback edge for every reference edge.

The phase error leaves the block as two pulses. A pump-up pulse asks the motor to speed up, and a pump-down pulse asks it to slow down. Each pulse lasts as many system clocks as the two edges are apart. When neither pulse is active, the loop-filter driver downstream holds its output in the idle state.

The block also reports two other things. It gives a one-clock strobe for each feedback rising edge. It gives a raw in-phase flag that is set once residual pulses stay shorter than a programmable number of clocks. The start/stop enable holds the comparator idle while the motor is stopped.

Top module: `pfd_edge_cmp`

## Requirements
- R1: After synchronous reset all outputs are low. An input that is already high when reset is released produces no edge and no fg_rise strobe.
- R2: When a reference falling edge comes d clocks before a feedback rising edge, pump_up is high for exactly d consecutive clocks and pump_dn stays low.
- R3: When a feedback rising edge comes d clocks before a reference falling edge, pump_dn is high for exactly d consecutive clocks and pump_up stays low.
- R4: Edges that fall in the same clock produce no pulse. pump_up and pump_dn are never high together.
- R5: Reference rising edges and feedback falling edges have no effect on pump_up or pump_dn.
- R6: A further reference falling edge while pump_up is already high keeps pump_up high in a single pulse until the next feedback rising edge. pump_up rises only while run is high.
- R7: While run is low, pump_up, pump_dn and in_phase are held low from the next clock on, and edges on either input start no pulse.
- R8: fg_rise is high for exactly one clock per feedback rising edge, one clock after the new level is sampled, whatever the state of run. pump_dn rises only in the clock after an fg_rise strobe.
- R9: An edge pair is short when its pulse width in clocks is below lock_win (a coincident pair has width 0). in_phase is set at the end of a pair that is short and follows a short pair. It is cleared at the end of any pair that is not short.
- R10: While a pulse is in progress and its width reaches lock_win, in_phase is cleared at once, before the pair completes.
- R11: The pulse width counter saturates at its maximum. A pulse longer than the counter range is never treated as a short pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start/stop enable, high = start |
| ref_in | input | 1 | Synchronized reference clock; its falling edge is the reference |
| fg_in | input | 1 | Speed feedback from Hall phase 1; its rising edge is the feedback |
| lock_win | input | LW | Short-pair threshold in system clocks |
| pump_up | output | 1 | Speed-up pulse, width equals reference lead |
| pump_dn | output | 1 | Slow-down pulse, width equals feedback lead |
| fg_rise | output | 1 | One-clock strobe per feedback rising edge |
| in_phase | output | 1 | Raw lock flag |

## Verification
The checker watches on every cycle that the two pump outputs are exclusive, that stop mode clears the outputs on the next clock, that fg_rise never lasts two clocks, and that every pump pulse starts with the right cause: an fg_rise strobe for pump_dn and the enable for pump_up. Exact pulse widths and the lock streak logic can only be shown by the bench's scenarios. So can the drop of the flag partway through a pulse and counter saturation on very long pulses. The bench drives chosen edge offsets for these and counts output cycles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter pfd_pkg::edge_kind_e KIND = pfd_pkg::EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic strobe
);
  logic prev_q;
  logic hit;

  generate
    if (KIND == pfd_pkg::EDGE_RISE) begin : g_rise
      assign hit = sig_in & ~prev_q;
    end else begin : g_fall
      assign hit = ~sig_in & prev_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= sig_in;   // adopt current level: no false edge on release
      strobe <= 1'b0;
    end else begin
      prev_q <= sig_in;
      strobe <= hit;
    end
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_evt,
  input  logic fb_evt,
  output logic up_q,
  output logic dn_q,
  output logic pair_evt
);
  logic nxt_up, nxt_dn, both;

  always_comb begin
    nxt_up = up_q | ref_evt;
    nxt_dn = dn_q | fb_evt;
    both   = nxt_up & nxt_dn;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      pair_evt <= 1'b0;
    end else if (both) begin
      up_q     <= 1'b0;   // both sides seen: clear together
      dn_q     <= 1'b0;
      pair_evt <= 1'b1;
    end else begin
      up_q     <= nxt_up;
      dn_q     <= nxt_dn;
      pair_evt <= 1'b0;
    end
  end
endmodule

// File: rtl/pfd_lock_meter.sv
module pfd_lock_meter #(
  parameter int CNT_W = 32,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          active,
  input  logic          pair_evt,
  input  logic [LW-1:0] lock_win,
  output logic          in_phase
);
  localparam int MW = (CNT_W > LW) ? CNT_W : LW;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             prev_good;
  logic             cur_good;
  logic             too_long;

  always_comb begin
    cur_good = MW'(cnt) < MW'(lock_win);
    too_long = active && !cur_good;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt       <= '0;
      prev_good <= 1'b0;
      in_phase  <= 1'b0;
    end else begin
      if (pair_evt) begin
        cnt       <= active ? CNT_W'(1) : '0;
        prev_good <= cur_good;
        in_phase  <= cur_good && prev_good;
      end else begin
        if (active)
          cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        else
          cnt <= '0;
        if (too_long)
          in_phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfd_edge_cmp.sv
module pfd_edge_cmp #(
  parameter int CNT_W = 32,
  parameter int LW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ref_in,
  input  logic          fg_in,
  input  logic [LW-1:0] lock_win,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          fg_rise,
  output logic          in_phase
);
  logic ref_evt, fb_evt, pair_evt;

  pfd_edge_det #(.KIND(pfd_pkg::EDGE_FALL)) u_ref_edge (
    .clk(clk), .rst(rst), .sig_in(ref_in), .strobe(ref_evt)
  );

  pfd_edge_det #(.KIND(pfd_pkg::EDGE_RISE)) u_fb_edge (
    .clk(clk), .rst(rst), .sig_in(fg_in), .strobe(fb_evt)
  );

  pfd_core u_core (
    .clk(clk), .rst(rst), .run(run),
    .ref_evt(ref_evt), .fb_evt(fb_evt),
    .up_q(pump_up), .dn_q(pump_dn), .pair_evt(pair_evt)
  );

  pfd_lock_meter #(.CNT_W(CNT_W), .LW(LW)) u_meter (
    .clk(clk), .rst(rst), .run(run),
    .active(pump_up | pump_dn), .pair_evt(pair_evt),
    .lock_win(lock_win), .in_phase(in_phase)
  );

  assign fg_rise = fb_evt;
endmodule

// File: rtl/pfd_edge_cmp_chk.sv
module pfd_edge_cmp_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic pump_up,
  input logic pump_dn,
  input logic fg_rise,
  input logic in_phase
);
  a_r4_mutex: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pump_up && !pump_dn && !in_phase));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
    fg_rise |=> !fg_rise);

  a_r8_dn_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_dn) |-> $past(fg_rise));

  a_r6_up_needs_run: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> $past(run));
endmodule

bind pfd_edge_cmp pfd_edge_cmp_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .pump_up(pump_up),
  .pump_dn(pump_dn), .fg_rise(fg_rise), .in_phase(in_phase)
);

// File: tb/sim_pfd_edge_cmp.sv
module sim_pfd_edge_cmp;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 6;
  localparam int LW     = 4;
  localparam int NVEC   = 8;

  // delta > 0: reference leads; fields: delta, up width, dn width, lock after
  typedef struct packed {
    logic signed [15:0] delta;
    logic [15:0] exp_up;
    logic [15:0] exp_dn;
    logic        exp_lock;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'sd5,  16'd5,  16'd0, 1'b0},
    '{-16'sd3, 16'd0,  16'd3, 1'b0},
    '{16'sd0,  16'd0,  16'd0, 1'b1},
    '{16'sd1,  16'd1,  16'd0, 1'b1},
    '{-16'sd1, 16'd0,  16'd1, 1'b1},
    '{16'sd20, 16'd20, 16'd0, 1'b0},
    '{16'sd2,  16'd2,  16'd0, 1'b0},
    '{-16'sd2, 16'd0,  16'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic ref_in = 1'b1;
  logic fg_in = 1'b1;
  logic [LW-1:0] lock_win = 4'd4;
  logic pump_up, pump_dn, fg_rise, in_phase;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pfd_edge_cmp #(.CNT_W(CNT_W), .LW(LW)) u0 (
    .clk(clk), .rst(rst), .run(run), .ref_in(ref_in), .fg_in(fg_in),
    .lock_win(lock_win), .pump_up(pump_up), .pump_dn(pump_dn),
    .fg_rise(fg_rise), .in_phase(in_phase)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one edge pair; counts pulse cycles over the window, restores idle levels
  task automatic edge_pair(input int delta, output int nup, output int ndn,
                           output int nfg, output int both);
    int a, b, win;
    a = (delta >= 0) ? 2 : 2 - delta;
    b = (delta >= 0) ? 2 + delta : 2;
    win = ((delta >= 0) ? delta : -delta) + 24;
    nup = 0; ndn = 0; nfg = 0; both = 0;
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      nup += int'(pump_up);
      ndn += int'(pump_dn);
      nfg += int'(fg_rise);
      both += int'(pump_up && pump_dn);
      if (c == a) ref_in = 1'b0;
      if (c == b) fg_in = 1'b1;
      if (c == win - 8) begin ref_in = 1'b1; fg_in = 1'b0; end // R5 inactive edges
    end
  endtask

  initial begin
    int nup, ndn, nfg, both, cnt_up;
    // R1: reset with both inputs high
    idle(3);
    rst = 1'b0;
    nfg = 0; nup = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      nfg += int'(fg_rise);
      nup += int'(pump_up) + int'(pump_dn) + int'(in_phase);
    end
    check("R1 outputs low after reset", nup, 0);
    check("R1 no strobe for high input", nfg, 0);
    fg_in = 1'b0;
    run = 1'b1;
    idle(3);

    // table walk: R2, R3, R4, R5, R8, R9
    for (int v = 0; v < NVEC; v++) begin
      edge_pair(int'(VECS[v].delta), nup, ndn, nfg, both);
      check($sformatf("R2 up width vec%0d", v), nup, int'(VECS[v].exp_up));
      check($sformatf("R3 dn width vec%0d", v), ndn, int'(VECS[v].exp_dn));
      check($sformatf("R4 exclusive vec%0d", v), both, 0);
      check($sformatf("R8 one strobe vec%0d", v), nfg, 1);
      check($sformatf("R9 lock vec%0d", v), int'(in_phase), int'(VECS[v].exp_lock));
    end

    // R10 and R6: lost feedback while locked
    edge_pair(1, nup, ndn, nfg, both);
    edge_pair(0, nup, ndn, nfg, both);
    check("R9 locked before loss", int'(in_phase), 1);
    ref_in = 1'b0;
    idle(int'(lock_win) + 4);
    check("R10 drop during pulse", int'(in_phase), 0);
    check("R10 pulse still high", int'(pump_up), 1);
    ref_in = 1'b1;
    idle(3);
    cnt_up = 0;
    ref_in = 1'b0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); cnt_up += int'(pump_up); end
    check("R6 up held across second ref edge", cnt_up, 4);
    fg_in = 1'b1;
    idle(5);
    check("R6 single pulse ends up", int'(pump_up), 0);
    check("R6 no dn after second ref edge", int'(pump_dn), 0);
    ref_in = 1'b1; fg_in = 1'b0;
    idle(4);

    // R11: two pulses longer than the counter range
    edge_pair(2, nup, ndn, nfg, both);
    edge_pair(1, nup, ndn, nfg, both);
    check("R9 relocked", int'(in_phase), 1);
    edge_pair(66, nup, ndn, nfg, both);
    check("R11 long up width", nup, 66);
    edge_pair(66, nup, ndn, nfg, both);
    check("R11 long pairs not short", int'(in_phase), 0);

    // R7: stop mode
    edge_pair(1, nup, ndn, nfg, both);
    edge_pair(1, nup, ndn, nfg, both);
    check("R9 lock before stop", int'(in_phase), 1);
    run = 1'b0;
    idle(2);
    check("R7 lock cleared", int'(in_phase), 0);
    edge_pair(5, nup, ndn, nfg, both);
    check("R7 no up while stopped", nup, 0);
    check("R7 no dn while stopped", ndn, 0);
    check("R8 strobe while stopped", nfg, 1);
    edge_pair(-4, nup, ndn, nfg, both);
    check("R7 no dn lead while stopped", ndn, 0);
    run = 1'b1;
    idle(2);
    edge_pair(3, nup, ndn, nfg, both);
    check("R2 up after restart", nup, 3);

    report();
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end
endmodule